// File: doc/BRIEF.md
# Inverter and Boost Gate-Drive Protection Core

This block sits between a motor-control processor and the gate drivers of a three-phase bridge with a boost converter switch. It receives seven active-high drive requests: a high-side and a low-side request for each of the three bridge legs, plus one boost request. It passes each request to its gate output only when every protection condition allows it.

The protection conditions come from two overcurrent comparators (bridge and boost), a main-supply undervoltage flag, three floating-supply undervoltage flags (one per leg), and an external enable level. The block reports serious faults on an open-drain style fault line, modelled as a pull-low request. All flags and requests are asynchronous and are brought into the clock domain through two-flop synchronizers. Drive pulses that are too short in either polarity are removed by a width filter.

An overcurrent trip clears by itself once the comparators have been quiet for a programmable clear time. An undervoltage lockout needs a new rising edge on the affected request before that output drives again.

Top module: `gate_protect`

## Requirements
- R1: After reset every gate output is off and the fault pull-low output is 0. A request input held low always gives an off output.
- R2: When the high-side and low-side requests of one leg are both active, both gate outputs of that leg are off. The fault output stays 0, and the other legs are unaffected.
- R3: An active flag from either the bridge or the boost overcurrent comparator turns off all seven gate outputs and sets fault_pull to 1.
- R4: After the overcurrent flags have gone inactive, the trip stays in force for CLEAR_CYC clock cycles. Drive then resumes by itself for requests that are still held.
- R5: If either overcurrent flag reasserts during the clear count, the count starts again from zero.
- R6: While the main-supply undervoltage flag is active, all gate outputs are off and fault_pull is 1 for the whole time.
- R7: An active floating-supply undervoltage flag for one leg turns off only that leg's high-side output and leaves fault_pull at 0.
- R8: After an undervoltage flag clears, an output that it blocked stays off until its request goes low and rises again. A request held high through the recovery does not turn the output back on.
- R9: While enable is low, all gate outputs are off, and the enable level alone does not set fault_pull.
- R10: A change of a request level, on or off, that lasts fewer than MIN_PULSE clock cycles does not reach the gate output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hs_req | input | 3 | High-side drive requests, bit 0/1/2 = leg U/V/W |
| ls_req | input | 3 | Low-side drive requests, bit 0/1/2 = leg U/V/W |
| boost_req | input | 1 | Boost switch drive request |
| oc_bridge | input | 1 | Bridge overcurrent comparator flag, active high |
| oc_boost | input | 1 | Boost overcurrent comparator flag, active high |
| uv_main | input | 1 | Main-supply undervoltage flag, active high |
| uv_float | input | 3 | Per-leg floating-supply undervoltage flags, active high |
| enable | input | 1 | Drive enable level, high allows drive |
| hs_gate | output | 3 | High-side gate outputs |
| ls_gate | output | 3 | Low-side gate outputs |
| boost_gate | output | 1 | Boost gate output |
| fault_pull | output | 1 | 1 = pull the open-drain fault line low |

## Verification
The overlap that matters most is an undervoltage recovery and a fresh request edge in the same held interval. The bench provokes it by changing a request and an undervoltage flag in one random step. A reference model applies the blocking flag before the edge, because the flag's path to the outputs is shorter than the width filter's delay, and predicts whether the output is re-armed. Random steps also combine leg shoot-through with undervoltage and enable changes. Directed runs overlap an overcurrent reassertion with a clear count already in progress and expect the trip to persist past the original clear point.

// File: rtl/gate_protect.sv
module gate_protect #(
  parameter int MIN_PULSE = 250,
  parameter int CLEAR_CYC = 250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hs_req,
  input  logic [2:0] ls_req,
  input  logic       boost_req,
  input  logic       oc_bridge,
  input  logic       oc_boost,
  input  logic       uv_main,
  input  logic [2:0] uv_float,
  input  logic       enable,
  output logic [2:0] hs_gate,
  output logic [2:0] ls_gate,
  output logic       boost_gate,
  output logic       fault_pull
);
  localparam int NCH = 7;
  localparam int NIN = 14;
  localparam int PW  = $clog2(MIN_PULSE + 1);
  localparam int CW  = $clog2(CLEAR_CYC + 1);

  logic [NIN-1:0] raw, s1, s2;
  assign raw = {enable, uv_float, uv_main, oc_boost, oc_bridge, boost_req, ls_req, hs_req};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end

  logic [NCH-1:0] req_s;
  logic           trip_s, uvm_s, en_s;
  logic [2:0]     uvf_s;
  assign req_s  = s2[6:0];
  assign trip_s = s2[7] | s2[8];
  assign uvm_s  = s2[9];
  assign uvf_s  = s2[12:10];
  assign en_s   = s2[13];

  logic [NCH-1:0] filt, filt_d;

  for (genvar g = 0; g < NCH; g++) begin : g_filt
    logic          f_q;
    logic [PW-1:0] c_q;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        f_q <= 1'b0;
        c_q <= '0;
      end else if (req_s[g] == f_q) begin
        c_q <= '0;
      end else if (c_q == PW'(MIN_PULSE - 1)) begin
        f_q <= req_s[g];
        c_q <= '0;
      end else begin
        c_q <= c_q + 1'b1;
      end
    assign filt[g] = f_q;
  end

  logic          trip_on;
  logic [CW-1:0] clr_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      trip_on <= 1'b0;
      clr_cnt <= '0;
    end else if (trip_s) begin
      trip_on <= 1'b1;
      clr_cnt <= '0;
    end else if (trip_on) begin
      if (clr_cnt == CW'(CLEAR_CYC - 1)) begin
        trip_on <= 1'b0;
        clr_cnt <= '0;
      end else begin
        clr_cnt <= clr_cnt + 1'b1;
      end
    end

  logic [NCH-1:0] blk, rise, arm, shoot, drive;
  logic           go;

  assign blk   = {uvm_s, {3{uvm_s}}, {3{uvm_s}} | uvf_s};
  assign rise  = filt & ~filt_d;
  assign shoot = {1'b0, filt[5:3] & filt[2:0], filt[5:3] & filt[2:0]};
  assign go    = en_s & ~trip_on & ~uvm_s;
  assign drive = filt & arm & ~blk & ~shoot & {NCH{go}};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      filt_d <= '0;
      arm    <= '0;
    end else begin
      filt_d <= filt;
      arm    <= (arm | rise) & ~blk;
    end

  assign hs_gate    = drive[2:0];
  assign ls_gate    = drive[5:3];
  assign boost_gate = drive[6];
  assign fault_pull = trip_on | uvm_s;

  // R2
  leg_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_gate & ls_gate) == 3'b000);

  // R3
  trip_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_s |=> (fault_pull && hs_gate == 3'b0 && ls_gate == 3'b0 && !boost_gate));

  // R4
  trip_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trip_on) |-> !$past(trip_s));

  // R6
  uv_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uvm_s |-> (fault_pull && hs_gate == 3'b0 && ls_gate == 3'b0 && !boost_gate));

  // R7
  uv_float_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|uvf_s && !uvm_s && !trip_on) |-> !fault_pull);

  // R7
  uv_float_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uvf_s & hs_gate) == 3'b000);

  // R9
  enable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |-> (hs_gate == 3'b0 && ls_gate == 3'b0 && !boost_gate));
endmodule

// File: tb/gate_protect_test.sv
module gate_protect_test;
  localparam int MINP = 4;
  localparam int CLR  = 40;
  localparam int HOLD = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] hs_req = '0, ls_req = '0, uv_float = '0;
  logic boost_req = 1'b0, oc_bridge = 1'b0, oc_boost = 1'b0, uv_main = 1'b0, enable = 1'b0;
  logic [2:0] hs_gate, ls_gate;
  logic boost_gate, fault_pull;

  gate_protect #(.MIN_PULSE(MINP), .CLEAR_CYC(CLR)) uut (
    .clk(clk), .rst_n(rst_n), .hs_req(hs_req), .ls_req(ls_req), .boost_req(boost_req),
    .oc_bridge(oc_bridge), .oc_boost(oc_boost), .uv_main(uv_main), .uv_float(uv_float),
    .enable(enable), .hs_gate(hs_gate), .ls_gate(ls_gate), .boost_gate(boost_gate),
    .fault_pull(fault_pull));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [6:0] m_arm = '0, m_prev = '0;
  logic [7:0] last_exp = '0;

  function automatic logic [7:0] model_out(input logic [6:0] req, input logic [6:0] armv,
                                          input logic uvm, input logic [2:0] uvf, input logic en);
    logic [6:0] blk, shoot, drv;
    blk   = {uvm, {3{uvm}}, {3{uvm}} | uvf};
    shoot = {1'b0, req[5:3] & req[2:0], req[5:3] & req[2:0]};
    drv   = req & armv & ~blk & ~shoot & {7{en & ~uvm}};
    return {uvm, drv};
  endfunction

  function automatic logic [7:0] observed();
    return {fault_pull, boost_gate, ls_gate, hs_gate};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag, input logic [2:0] hs, input logic [2:0] ls, input logic b,
                      input logic uvm, input logic [2:0] uvf, input logic en);
    logic [6:0] req, blk;
    req = {b, ls, hs};
    blk = {uvm, {3{uvm}}, {3{uvm}} | uvf};
    m_arm  = (m_arm | (req & ~m_prev)) & ~blk;
    m_prev = req;
    last_exp = model_out(req, m_arm, uvm, uvf, en);
    hs_req = hs; ls_req = ls; boost_req = b; uv_main = uvm; uv_float = uvf; enable = en;
    repeat (HOLD) @(negedge clk);
    check(tag, observed(), last_exp);
  endtask

  task automatic hold_bit(input string tag, input int idx, input logic lvl, input int n);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (observed()[idx] !== lvl) ok = 1'b0;
    end
    check(tag, {7'b0, ok}, 8'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1729));
    repeat (3) @(negedge clk);
    check("R1 reset state", observed(), 8'h00);
    rst_n = 1'b1;
    enable = 1'b1;
    repeat (HOLD) @(negedge clk);
    check("R1 idle low inputs", observed(), 8'h00);

    step("R1 single drives", 3'b001, 3'b010, 1'b1, 1'b0, 3'b000, 1'b1);
    step("R2 leg U overlap", 3'b101, 3'b011, 1'b1, 1'b0, 3'b000, 1'b1);
    step("R9 enable low", 3'b101, 3'b010, 1'b1, 1'b0, 3'b000, 1'b0);
    step("R9 enable back", 3'b101, 3'b010, 1'b1, 1'b0, 3'b000, 1'b1);

    step("R8 arm leg V", 3'b010, 3'b000, 1'b0, 1'b0, 3'b000, 1'b1);
    step("R7 float uv leg V", 3'b010, 3'b000, 1'b0, 1'b0, 3'b010, 1'b1);
    step("R8 held request after recovery", 3'b010, 3'b000, 1'b0, 1'b0, 3'b000, 1'b1);
    step("R8 request low", 3'b000, 3'b000, 1'b0, 1'b0, 3'b000, 1'b1);
    step("R8 fresh edge", 3'b010, 3'b000, 1'b0, 1'b0, 3'b000, 1'b1);
    step("R6 main uv", 3'b010, 3'b100, 1'b1, 1'b1, 3'b000, 1'b1);
    step("R8 main uv recovery held", 3'b010, 3'b100, 1'b1, 1'b0, 3'b000, 1'b1);

    step("R10 setup on", 3'b000, 3'b001, 1'b0, 1'b0, 3'b000, 1'b1);
    ls_req[0] = 1'b0;
    repeat (MINP - 2) @(negedge clk);
    ls_req[0] = 1'b1;
    hold_bit("R10 short off glitch", 3, 1'b1, 20);
    step("R10 setup off", 3'b000, 3'b000, 1'b0, 1'b0, 3'b000, 1'b1);
    ls_req[0] = 1'b1;
    repeat (MINP - 2) @(negedge clk);
    ls_req[0] = 1'b0;
    hold_bit("R10 short on glitch", 3, 1'b0, 20);

    step("R3 drives before trip", 3'b001, 3'b100, 1'b1, 1'b0, 3'b000, 1'b1);
    oc_bridge = 1'b1;
    repeat (6) @(negedge clk);
    check("R3 bridge trip", observed(), 8'h80);
    oc_bridge = 1'b0;
    repeat (20) @(negedge clk);
    check("R4 still tripped", observed(), 8'h80);
    repeat (40) @(negedge clk);
    check("R4 auto resume", observed(), last_exp);
    oc_boost = 1'b1;
    repeat (6) @(negedge clk);
    check("R3 boost trip", observed(), 8'h80);
    oc_boost = 1'b0;
    repeat (25) @(negedge clk);
    oc_boost = 1'b1;
    repeat (3) @(negedge clk);
    oc_boost = 1'b0;
    repeat (25) @(negedge clk);
    check("R5 count restarted", observed(), 8'h80);
    repeat (40) @(negedge clk);
    check("R5 resume after restart", observed(), last_exp);

    for (int k = 0; k < 300; k++) begin
      logic [2:0] hs, ls, uvf;
      logic b, uvm, en;
      hs  = 3'($urandom);
      ls  = 3'($urandom);
      b   = 1'($urandom);
      uvm = ($urandom % 8) == 0;
      uvf = {($urandom % 6) == 0, ($urandom % 6) == 0, ($urandom % 6) == 0};
      en  = ($urandom % 10) != 0;
      step("R2 R6 R7 R8 R9 random", hs, ls, b, uvm, uvf, en);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule